// File: doc/BRIEF.md
# Parallel Sigma-Point Mean and Covariance Engine

This block turns a set of N sigma-point vectors, each of dimension M, into a weighted mean vector and a weighted covariance matrix. It works in three strict phases. First it reads every sigma point from an external read port and forms the weighted mean. Then it reads the points a second time and stores each residual, which is the point minus the mean, in an internal residual memory. Last it forms every covariance element from the stored residuals. The first sigma point carries weight W0 and every other point carries weight W1. Both weights are signed fixed-point parameters with WF fractional bits.

NPE processing lanes work side by side, and each lane owns one row of the current row group. Row groups start at 0, NPE, 2·NPE and so on. Within a group, each mean beat and each covariance beat delivers up to NPE results at once. The cost of the covariance phase therefore scales as ceil(M/NPE)·M·N cycles, which falls to M·N when NPE ≥ M. A one-cycle start pulse launches a run. A one-cycle done pulse closes it.

Top module: `sigma_stats`

## Requirements
- R1: Each mean element is mean[i] = floor((W0·x0[i] + W1·Σ_{k=1..N-1} xk[i]) / 2^WF). It is delivered on a result beat with res_cov=0 and res_col=0.
- R2: Each covariance element is P[i][j] = floor(Σ_k W(k)·r[i][k]·r[j][k] / 2^WF). Here r[i][k] = xk[i] − mean[i], with the mean held to DW+2 bits, and W(0)=W0 and W(k>0)=W1. Every element starts from zero, so nothing carries over from a previous element or a previous run.
- R3: All mean beats of a run come before any covariance beat. All sigma-point reads (rd_en) finish before the first covariance beat.
- R4: On each beat, res_row is the group base row. Base rows rise in steps of NPE starting at 0, and within a group the covariance beats run res_col = 0..M−1 in ascending order. Lane p carries row res_row+p in res_data[p·OW +: OW]. res_lane_en[p] is 1 exactly when res_row+p < M, and lane 0 is always enabled.
- R5: done is a one-cycle pulse. It comes in the cycle right after the final covariance beat, and no result is still owed at that point.
- R6: done rises G·N + N + 1 + G·M·N + 2 clock edges after the edge that accepts start, where G = ceil(M/NPE).
- R7: A start pulse that arrives while a run is in progress is ignored. It changes neither the results nor the latency of that run.
- R8: While reset is held, res_valid, done and rd_en are all 0.
- R9: Each run makes G+1 read passes. In every pass rd_addr runs 0..N−1 in order, one address per cycle. Point k's element i is returned on rd_data[i·DW +: DW] in the cycle after rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches a run when idle |
| rd_en | output | 1 | Sigma-point read request |
| rd_addr | output | KW | Sigma-point index being read |
| rd_data | input | M·DW | Whole sigma-point vector, one cycle after rd_en |
| res_valid | output | 1 | Result beat valid |
| res_cov | output | 1 | 0 = mean beat, 1 = covariance beat |
| res_row | output | IW | Base row of the lane group |
| res_col | output | CW | Covariance column (0 on mean beats) |
| res_lane_en | output | NPE | Per-lane valid mask |
| res_data | output | NPE·OW | Per-lane signed results |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses a row count that NPE does not divide, so the last group has masked lanes. A design that left those lanes enabled, or indexed past row M−1, would emit extra or corrupted results. Three other runs target specific faults. A run with identical sigma points should give all-zero residuals and covariance, and any stale accumulator or residual from the run before would show up as a non-zero value. Random and signed patterns with a negative W0 expose faults in the floor rounding of negative sums and in weight selection for point 0. A start pulse in the middle of a run, together with the exact latency check, would catch a controller that restarts, skips a phase or starts the covariance phase before the residuals are stored.

// File: rtl/sstat_pkg.sv
package sstat_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_MEAN,
    PH_RESID,
    PH_DRAIN,
    PH_COV,
    PH_FIN
  } phase_e;
endpackage

// File: rtl/sstat_ctrl.sv
module sstat_ctrl
  import sstat_pkg::*;
#(
  parameter int M   = 4,
  parameter int N   = 9,
  parameter int NPE = 2,
  localparam int KW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = (M > 1) ? $clog2(M) : 1,
  localparam int IW = $clog2(M + NPE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          fin,
  output phase_e        ph,
  output logic          iss_valid,
  output logic          iss_first,
  output logic          iss_last,
  output logic          iss_end,
  output logic [KW-1:0] iss_k,
  output logic [IW-1:0] iss_grp,
  output logic [CW-1:0] iss_col
);
  phase_e        st;
  logic [KW-1:0] k;
  logic [IW-1:0] grp;
  logic [CW-1:0] col;
  logic          k_last, col_last, grp_last;

  assign k_last   = (int'(k) == N - 1);
  assign col_last = (int'(col) == M - 1);
  assign grp_last = (int'(grp) + NPE >= M);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= PH_IDLE;
      k   <= '0;
      grp <= '0;
      col <= '0;
    end else begin
      case (st)
        PH_IDLE: if (start) begin
          st  <= PH_MEAN;
          k   <= '0;
          grp <= '0;
          col <= '0;
        end
        PH_MEAN: begin
          if (k_last) begin
            k <= '0;
            if (grp_last) begin
              grp <= '0;
              st  <= PH_RESID;
            end else begin
              grp <= grp + IW'(NPE);
            end
          end else begin
            k <= k + KW'(1);
          end
        end
        PH_RESID: begin
          if (k_last) begin
            k  <= '0;
            st <= PH_DRAIN;
          end else begin
            k <= k + KW'(1);
          end
        end
        PH_DRAIN: st <= PH_COV;
        PH_COV: begin
          if (k_last) begin
            k <= '0;
            if (col_last) begin
              col <= '0;
              if (grp_last) begin
                grp <= '0;
                st  <= PH_FIN;
              end else begin
                grp <= grp + IW'(NPE);
              end
            end else begin
              col <= col + CW'(1);
            end
          end else begin
            k <= k + KW'(1);
          end
        end
        PH_FIN: if (fin) st <= PH_IDLE;
        default: st <= PH_IDLE;
      endcase
    end
  end

  assign ph        = st;
  assign iss_valid = (st == PH_MEAN) || (st == PH_RESID) || (st == PH_COV);
  assign iss_first = (k == '0);
  assign iss_last  = k_last;
  assign iss_end   = (st == PH_COV) && k_last && col_last && grp_last;
  assign iss_k     = k;
  assign iss_grp   = grp;
  assign iss_col   = col;
endmodule

// File: rtl/sstat_resmem.sv
module sstat_resmem #(
  parameter int DEPTH = 9,
  parameter int WIDTH = 72,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/sstat_pe.sv
module sstat_pe #(
  parameter int RW   = 18,
  parameter int WW   = 16,
  parameter int ACCW = 57
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   first,
  input  logic signed [RW-1:0]   a,
  input  logic signed [RW-1:0]   b,
  input  logic signed [WW-1:0]   w,
  output logic signed [ACCW-1:0] acc_nxt,
  output logic signed [ACCW-1:0] acc
);
  logic signed [ACCW-1:0] ax, bx, wx, term, base;

  assign ax      = ACCW'(a);
  assign bx      = ACCW'(b);
  assign wx      = ACCW'(w);
  assign term    = wx * ax * bx;
  assign base    = first ? '0 : acc;
  assign acc_nxt = base + term;

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else if (en) acc <= acc_nxt;
  end
endmodule

// File: rtl/sigma_stats.sv
module sigma_stats
  import sstat_pkg::*;
#(
  parameter int M   = 4,
  parameter int N   = 9,
  parameter int NPE = 2,
  parameter int DW  = 16,
  parameter int WW  = 16,
  parameter int WF  = 10,
  parameter int W0  = -512,
  parameter int W1  = 192,
  localparam int KW   = (N > 1) ? $clog2(N) : 1,
  localparam int CW   = (M > 1) ? $clog2(M) : 1,
  localparam int IW   = $clog2(M + NPE),
  localparam int RW   = DW + 2,
  localparam int ACCW = 2 * RW + WW + KW + 1,
  localparam int OW   = ACCW - WF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              rd_en,
  output logic [KW-1:0]     rd_addr,
  input  logic [M*DW-1:0]   rd_data,
  output logic              res_valid,
  output logic              res_cov,
  output logic [IW-1:0]     res_row,
  output logic [CW-1:0]     res_col,
  output logic [NPE-1:0]    res_lane_en,
  output logic [NPE*OW-1:0] res_data,
  output logic              done
);
  phase_e        ph, s1_ph;
  logic          iss_valid, iss_first, iss_last, iss_end;
  logic [KW-1:0] iss_k, s1_k;
  logic [IW-1:0] iss_grp, s1_grp;
  logic [CW-1:0] iss_col, s1_col;
  logic          s1_v, s1_first, s1_last, s1_end, res_last;

  sstat_ctrl #(.M(M), .N(N), .NPE(NPE)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .fin(done), .ph(ph),
    .iss_valid(iss_valid), .iss_first(iss_first), .iss_last(iss_last),
    .iss_end(iss_end), .iss_k(iss_k), .iss_grp(iss_grp), .iss_col(iss_col)
  );

  assign rd_en   = (ph == PH_MEAN) || (ph == PH_RESID);
  assign rd_addr = iss_k;

  // One pipeline stage covers the read latency of both memories
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0; s1_ph <= PH_IDLE; s1_first <= 1'b0; s1_last <= 1'b0;
      s1_end <= 1'b0; s1_k <= '0; s1_grp <= '0; s1_col <= '0;
    end else begin
      s1_v <= iss_valid; s1_ph <= ph; s1_first <= iss_first; s1_last <= iss_last;
      s1_end <= iss_end; s1_k <= iss_k; s1_grp <= iss_grp; s1_col <= iss_col;
    end
  end

  logic signed [DW-1:0] x_arr  [M];
  logic signed [RW-1:0] r_arr  [M];
  logic signed [RW-1:0] mean_q [M];
  logic [M*RW-1:0]      rm_wdata, rm_q;

  for (genvar i = 0; i < M; i++) begin : g_unpack
    assign x_arr[i] = rd_data[i*DW +: DW];
    assign r_arr[i] = rm_q[i*RW +: RW];
    assign rm_wdata[i*RW +: RW] = RW'(x_arr[i]) - mean_q[i];
  end

  sstat_resmem #(.DEPTH(N), .WIDTH(M*RW)) u_resmem (
    .clk(clk),
    .we(s1_v && (s1_ph == PH_RESID)), .waddr(s1_k), .wdata(rm_wdata),
    .re(iss_valid && (ph == PH_COV)), .raddr(iss_k), .q(rm_q)
  );

  logic signed [WW-1:0]   wsel;
  logic                   pe_en;
  logic signed [ACCW-1:0] acc_nxt [NPE];
  logic signed [ACCW-1:0] acc_q   [NPE];
  logic [CW-1:0]          lane_ci [NPE];
  logic [NPE-1:0]         lane_ok;

  assign wsel  = (s1_k == '0) ? WW'(W0) : WW'(W1);
  assign pe_en = s1_v && ((s1_ph == PH_MEAN) || (s1_ph == PH_COV));

  for (genvar p = 0; p < NPE; p++) begin : g_lane
    logic [IW-1:0]        rix;
    logic signed [RW-1:0] a_in, b_in;
    assign rix        = s1_grp + IW'(p);
    assign lane_ok[p] = (int'(rix) < M);
    assign lane_ci[p] = lane_ok[p] ? CW'(rix) : '0;
    assign a_in = (s1_ph == PH_MEAN) ? RW'(x_arr[lane_ci[p]]) : r_arr[lane_ci[p]];
    assign b_in = (s1_ph == PH_MEAN) ? RW'(1) : r_arr[s1_col];

    sstat_pe #(.RW(RW), .WW(WW), .ACCW(ACCW)) u_pe (
      .clk(clk), .rst(rst), .en(pe_en), .first(s1_first),
      .a(a_in), .b(b_in), .w(wsel), .acc_nxt(acc_nxt[p]), .acc(acc_q[p])
    );

    assign res_data[p*OW +: OW] = OW'(acc_q[p] >>> WF);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < M; i++) mean_q[i] <= '0;
    end else if (s1_v && s1_last && (s1_ph == PH_MEAN)) begin
      for (int p = 0; p < NPE; p++)
        if (lane_ok[p]) mean_q[lane_ci[p]] <= RW'(acc_nxt[p] >>> WF);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0; res_cov <= 1'b0; res_row <= '0; res_col <= '0;
      res_lane_en <= '0; res_last <= 1'b0; done <= 1'b0;
    end else begin
      res_valid   <= pe_en && s1_last;
      res_cov     <= (s1_ph == PH_COV);
      res_row     <= s1_grp;
      res_col     <= s1_col;
      res_lane_en <= lane_ok;
      res_last    <= pe_en && s1_last && s1_end;
      done        <= res_valid && res_last;
    end
  end
endmodule

// File: rtl/sigma_stats_chk.sv
module sigma_stats_chk #(
  parameter int M   = 4,
  parameter int NPE = 2,
  localparam int CW = (M > 1) ? $clog2(M) : 1,
  localparam int IW = $clog2(M + NPE)
) (
  input logic           clk,
  input logic           rst,
  input logic           rd_en,
  input logic           res_valid,
  input logic           res_cov,
  input logic [IW-1:0]  res_row,
  input logic [CW-1:0]  res_col,
  input logic [NPE-1:0] res_lane_en,
  input logic           done
);
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_after_cov_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(res_valid && res_cov));
  p_no_read_in_cov_r3: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_cov) |-> !rd_en);
  p_row_range_r4: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (int'(res_row) < M));
  p_mean_col_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_cov) |-> (res_col == '0));
  p_lane0_on_r4: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> res_lane_en[0]);
endmodule

bind sigma_stats sigma_stats_chk #(.M(M), .NPE(NPE)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .res_valid(res_valid), .res_cov(res_cov),
  .res_row(res_row), .res_col(res_col), .res_lane_en(res_lane_en), .done(done)
);

// File: tb/tb_sigma_stats.sv
module tb_sigma_stats;
  localparam int M = 4, N = 9, NPE = 3, DW = 16, WW = 16, WF = 10;
  localparam int W0 = -512, W1 = 192;
  localparam int KW = (N > 1) ? $clog2(N) : 1;
  localparam int CW = (M > 1) ? $clog2(M) : 1;
  localparam int IW = $clog2(M + NPE);
  localparam int RW = DW + 2;
  localparam int ACCW = 2 * RW + WW + KW + 1;
  localparam int OW = ACCW - WF;
  localparam int G = (M + NPE - 1) / NPE;
  localparam int LAT = G * N + N + 1 + G * M * N + 2;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic rd_en, res_valid, res_cov, done;
  logic [KW-1:0] rd_addr;
  logic [M*DW-1:0] rd_data = '0;
  logic [IW-1:0] res_row;
  logic [CW-1:0] res_col;
  logic [NPE-1:0] res_lane_en;
  logic [NPE*OW-1:0] res_data;

  always #4 clk = ~clk;

  sigma_stats #(.M(M), .N(N), .NPE(NPE), .DW(DW), .WW(WW), .WF(WF), .W0(W0), .W1(W1)) dut (
    .clk(clk), .rst(rst), .start(start), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .res_valid(res_valid), .res_cov(res_cov), .res_row(res_row), .res_col(res_col),
    .res_lane_en(res_lane_en), .res_data(res_data), .done(done)
  );

  int pts [N][M];
  always @(posedge clk)
    if (rd_en)
      for (int i = 0; i < M; i++) rd_data[i*DW +: DW] <= DW'(pts[rd_addr][i]);

  typedef struct { bit cov; int row; int col; longint val; } item_t;
  item_t exp_q[$];
  item_t e;
  int checks = 0, fails = 0, rd_cnt = 0, total = 0;
  bit cov_seen = 0, done_prev = 0, en_exp;
  longint got;

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic longint wgt(int k);
    return (k == 0) ? longint'(W0) : longint'(W1);
  endfunction

  // Driver side of the scoreboard: reference results in emission order
  task automatic build_expect();
    longint mean [M];
    longint r [N][M];
    longint s;
    item_t it;
    for (int i = 0; i < M; i++) begin
      s = 0;
      for (int k = 0; k < N; k++) s += wgt(k) * longint'(pts[k][i]);
      mean[i] = s >>> WF;
      for (int k = 0; k < N; k++) r[k][i] = longint'(pts[k][i]) - mean[i];
    end
    for (int g = 0; g < M; g += NPE)
      for (int p = 0; p < NPE; p++)
        if (g + p < M) begin
          it.cov = 0; it.row = g + p; it.col = 0; it.val = mean[g + p];
          exp_q.push_back(it);
        end
    for (int g = 0; g < M; g += NPE)
      for (int j = 0; j < M; j++)
        for (int p = 0; p < NPE; p++)
          if (g + p < M) begin
            s = 0;
            for (int k = 0; k < N; k++) s += wgt(k) * r[k][g + p] * r[k][j];
            it.cov = 1; it.row = g + p; it.col = j; it.val = s >>> WF;
            exp_q.push_back(it);
          end
  endtask

  // Monitor side of the scoreboard
  always @(negedge clk) begin
    if (rst) begin
      chk(!res_valid && !done && !rd_en, "R8", "outputs during reset",
          {res_valid, done, rd_en}, 0);
    end else begin
      if (rd_en) begin
        chk(int'(rd_addr) == rd_cnt % N, "R9", "read address", rd_addr, rd_cnt % N);
        rd_cnt++;
      end
      if (res_valid) begin
        if (res_cov) cov_seen = 1;
        else chk(!cov_seen, "R3", "mean beat after covariance beat", 1, 0);
        for (int p = 0; p < NPE; p++) begin
          en_exp = (int'(res_row) + p < M);
          chk(res_lane_en[p] == en_exp, "R4", "lane enable", res_lane_en[p], en_exp);
          if (res_lane_en[p]) begin
            if (exp_q.size() == 0) chk(0, "R2", "unexpected result beat", 1, 0);
            else begin
              e = exp_q.pop_front();
              got = longint'(signed'(res_data[p*OW +: OW]));
              chk(res_cov == e.cov && int'(res_row) + p == e.row && int'(res_col) == e.col,
                  "R4", "result position (row)", int'(res_row) + p, e.row);
              chk(got == e.val, e.cov ? "R2" : "R1", "result value", got, e.val);
            end
          end
        end
      end
      if (done) begin
        chk(exp_q.size() == 0, "R5", "results pending at done", exp_q.size(), 0);
        chk(!done_prev, "R5", "done longer than one cycle", 1, 0);
      end
      done_prev = done;
    end
  end

  task automatic run(int poke);
    int cyc;
    @(posedge clk);
    build_expect();
    rd_cnt = 0;
    cov_seen = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      start = (cyc == poke);
    end
    start = 1'b0;
    if (cyc >= 5000) chk(0, "R5", "watchdog expired", cyc, LAT);
    else if (poke > 0) chk(cyc == LAT, "R7", "latency with mid-run start", cyc, LAT);
    else chk(cyc == LAT, "R6", "start-to-done latency", cyc, LAT);
    @(negedge clk);
    chk(rd_cnt == (G + 1) * N, "R9", "read count", rd_cnt, (G + 1) * N);
    chk(exp_q.size() == 0, "R3", "results left over", exp_q.size(), 0);
    exp_q.delete();
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) begin
    total++;
    if (total > 190000) begin
      fails++;
      $display("FAIL R5 global watchdog actual=%0d expected=%0d", total, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // ramp pattern
    for (int k = 0; k < N; k++) for (int i = 0; i < M; i++) pts[k][i] = k * 37 + i * 11 - 150;
    run(0);
    // random signed values
    for (int k = 0; k < N; k++) for (int i = 0; i < M; i++)
      pts[k][i] = int'($urandom_range(2000)) - 1000;
    run(0);
    // identical points with a start pulse mid-run: zero covariance, R7
    for (int k = 0; k < N; k++) for (int i = 0; i < M; i++) pts[k][i] = 321 - 7 * i;
    run(30);
    // outlier first point, negative others
    for (int k = 0; k < N; k++) for (int i = 0; i < M; i++)
      pts[k][i] = (k == 0) ? 900 - i : -50 * i - 3 * k;
    run(0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule